// File: doc/BRIEF.md
# Lockable Code-Memory Access Port

This block sits on the target side of a debug register bus and gives that bus access to the on-chip code memory. The bus reaches six byte registers: core control, memory control, the high and low halves of a 16-bit address, a data window and a status register. A debugger first holds the processor core in reset and sets memory control to read mode. It then loads the address and streams bytes through the data window. The address steps forward by one after every data access.

The code memory is modelled as a synchronous array that behaves like one-time-programmable storage. It starts blank, with every bit at 1. A write can only clear bits: the stored byte becomes old AND new. The last location of the array holds a security byte. Its upper nibble is the write-protect field and its lower nibble is the read-protect field. A single 0 bit anywhere in a field shuts the port for that kind of access across the whole memory. Cleared bits can never be set again, so a lock cannot be undone, and a reset does not undo it either. The status register reports both lock states and a sticky error flag.

Top module: `lockmem_port`

## Requirements
- R1: After reset, `core_hold` is 0, the core-control readback is 0x00, both address bytes read 0x00 and status reads 0x00 while the security byte is still blank.
- R2: Writing 0x04 to core control (index 0) sets `core_hold`. Writing 0x02 also sets it and arms a release. A following write of 0x00 clears `core_hold`. A write of 0x00 without that arming leaves `core_hold` at 1. Core control reads back as {7'b0, core_hold}.
- R3: Data accesses (index 4) are accepted only while `core_hold` is 1 and memory control (index 1) holds 0x00. In any other case a data access leaves memory and the address unchanged, reads return 0x00 and the error flag is set.
- R4: An accepted, unlocked data read returns the byte at the memory location given by the low address bits. The 16-bit address (high byte at index 2, low byte at index 3) then increments by one and wraps from 0xFFFF to 0x0000.
- R5: An accepted, unlocked data write stores old AND written value at the current location, then increments the address.
- R6: The security byte is the last array location (address 0x00FF with the defaults). If any of its bits 7:4 is 0, every data write is blocked: memory is unchanged, the error flag is set and the address still increments.
- R7: If any of bits 3:0 of the security byte is 0, every data read is blocked: it returns 0x00, sets the error flag and still increments the address.
- R8: Status (index 5) reads {5'b0, write-locked, read-locked, error}.
- R9: The error flag stays set until either address register is written. That write clears it.
- R10: A lock cannot be removed. Writing 0xFF or any other value to the security byte, or resetting the block, never returns a cleared lock bit to 1.
- R11: A register read with `bus_rd` at a clock edge presents its value on `bus_rdata` from that edge on. The value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register index |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid after the read edge |
| core_hold | output | 1 | Holds the processor core in reset |

## Verification
Streamed writes and reads over consecutive addresses show that the address steps forward once per access and that each byte lands in its own cell. Writing a pattern over an already programmed byte separates AND-only programming from plain overwrite. A read at 0xFFFF shows both the address wrap and the index folding onto the security byte. Two separate instances are used so that write protection and read protection can each be observed through data that can still be read back. Attempts to rewrite the lock and a reset check that a lock, once cleared, stays in force.

// File: rtl/lockmem_pkg.sv
// Shared register indices and status layout for the lockable memory port.
// Assumes a 3-bit register index on the debug bus.
package lockmem_pkg;
    typedef enum logic [2:0] {
        REG_CORE   = 3'd0,
        REG_MEMCTL = 3'd1,
        REG_ADDRH  = 3'd2,
        REG_ADDRL  = 3'd3,
        REG_DATA   = 3'd4,
        REG_STATUS = 3'd5
    } reg_idx_e;

    localparam logic [7:0] CORE_HOLD_CMD = 8'h04;
    localparam logic [7:0] CORE_ARM_CMD  = 8'h02;
    localparam logic [7:0] CORE_GO_CMD   = 8'h00;
    localparam logic [7:0] MEM_READ_MODE = 8'h00;
endpackage

// File: rtl/lockmem_otp_array.sv
// One-time-programmable code memory model.
// Starts blank (all ones). A write clears bits only: cell <= cell & data.
// Read is synchronous; the security byte at the last location is exposed
// continuously. Assumes read and write are never requested together.
module lockmem_otp_array #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] sec_byte
);
    localparam int SEC_IDX = DEPTH - 1;

    logic [DW-1:0] cells [DEPTH];

    // Blank the array once at power-up; reset must not restore programmed bits.
    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = '1;
    end

    // Program by clearing bits only.
    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= cells[idx] & wdata;
    end

    // Synchronous read port.
    always_ff @(posedge clk) begin
        if (rd_en) rdata <= cells[idx];
    end

    assign sec_byte = cells[SEC_IDX];

    // A cleared security bit never comes back.
    p_sec_no_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((sec_byte & ~$past(sec_byte)) == '0));
endmodule

// File: rtl/lockmem_lock_decode.sv
// Decodes the security byte: a single 0 bit in a nibble locks that access type.
// Upper nibble guards writes, lower nibble guards reads.
module lockmem_lock_decode #(
    parameter int DW = 8,
    localparam int HALF = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] sec_byte,
    output logic          rd_locked,
    output logic          wr_locked
);
    // Any cleared bit in a field engages that lock.
    always_comb begin
        wr_locked = ~&sec_byte[DW-1:HALF];
        rd_locked = ~&sec_byte[HALF-1:0];
    end

    p_wr_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_locked) |-> wr_locked);
    p_rd_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_locked) |-> rd_locked);
endmodule

// File: rtl/lockmem_core_ctl.sv
// Core reset control: 0x04 holds the core, 0x02 holds and arms release,
// 0x00 after arming releases. Other values are ignored.
module lockmem_core_ctl
    import lockmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic       core_hold
);
    logic armed;

    // Track hold and the two-step release sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_hold <= 1'b0;
            armed     <= 1'b0;
        end else if (wr_en) begin
            if (wdata == CORE_HOLD_CMD) begin
                core_hold <= 1'b1;
                armed     <= 1'b0;
            end else if (wdata == CORE_ARM_CMD) begin
                core_hold <= 1'b1;
                armed     <= 1'b1;
            end else if (wdata == CORE_GO_CMD && armed) begin
                core_hold <= 1'b0;
                armed     <= 1'b0;
            end
        end
    end

    p_hold_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == CORE_HOLD_CMD) |=> core_hold);
    p_release_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && !(wr_en && wdata == CORE_GO_CMD)) |=> core_hold);
endmodule

// File: rtl/lockmem_port.sv
// Debug-bus register block giving access to lockable OTP code memory.
// Assumes bus_wr and bus_rd are single-cycle strobes; a write wins if both
// are raised. Read data appears after the clock edge that takes bus_rd.
module lockmem_port
    import lockmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 256,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       core_hold
);
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_ctl;
    logic              err_flag;
    logic [7:0]        sec_byte, arr_rdata, reg_q;
    logic              rd_locked, wr_locked, from_arr_q;
    logic              take_rd, data_rd, data_wr, gate_open, rd_ok, wr_ok, step, fault;
    logic              addr_wr;

    // Decode bus strobes against the access gate and lock state.
    always_comb begin
        take_rd   = bus_rd && !bus_wr;
        data_rd   = take_rd && bus_addr == REG_DATA;
        data_wr   = bus_wr && bus_addr == REG_DATA;
        gate_open = core_hold && mem_ctl == MEM_READ_MODE;
        rd_ok     = data_rd && gate_open && !rd_locked;
        wr_ok     = data_wr && gate_open && !wr_locked;
        step      = (data_rd || data_wr) && gate_open;
        fault     = (data_rd || data_wr) && !(rd_ok || wr_ok);
        addr_wr   = bus_wr && (bus_addr == REG_ADDRH || bus_addr == REG_ADDRL);
    end

    lockmem_core_ctl u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && bus_addr == REG_CORE),
        .wdata    (bus_wdata),
        .core_hold(core_hold)
    );

    lockmem_otp_array #(.DEPTH(DEPTH), .DW(8)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .rd_en   (rd_ok),
        .idx     (mem_addr[IW-1:0]),
        .wdata   (bus_wdata),
        .rdata   (arr_rdata),
        .sec_byte(sec_byte)
    );

    lockmem_lock_decode #(.DW(8)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_byte (sec_byte),
        .rd_locked(rd_locked),
        .wr_locked(wr_locked)
    );

    // Memory-control register.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_ctl <= '0;
        else if (bus_wr && bus_addr == REG_MEMCTL) mem_ctl <= bus_wdata;
    end

    // Address register: loaded by halves, stepped by data accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_addr <= '0;
        else if (bus_wr && bus_addr == REG_ADDRH) mem_addr[ADDR_W-1:8] <= bus_wdata;
        else if (bus_wr && bus_addr == REG_ADDRL) mem_addr[7:0] <= bus_wdata;
        else if (step) mem_addr <= mem_addr + 1'b1;
    end

    // Sticky error flag, cleared by an address load.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else if (addr_wr) err_flag <= 1'b0;
        else if (fault) err_flag <= 1'b1;
    end

    // Capture register readback; data-window reads come from the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q      <= '0;
            from_arr_q <= 1'b0;
        end else if (take_rd) begin
            from_arr_q <= rd_ok;
            case (bus_addr)
                REG_CORE:   reg_q <= {7'b0, core_hold};
                REG_MEMCTL: reg_q <= mem_ctl;
                REG_ADDRH:  reg_q <= mem_addr[ADDR_W-1:8];
                REG_ADDRL:  reg_q <= mem_addr[7:0];
                REG_STATUS: reg_q <= {5'b0, wr_locked, rd_locked, err_flag};
                default:    reg_q <= '0;
            endcase
        end
    end

    assign bus_rdata = from_arr_q ? arr_rdata : reg_q;

    p_step_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_wr) |=> mem_addr == $past(mem_addr) + 1'b1);
    p_closed_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !addr_wr) |=> $stable(mem_addr));
    p_locked_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rd_locked) |=> bus_rdata == 8'h00);
    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> !err_flag);
    p_fault_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !addr_wr) |=> err_flag);
endmodule

// File: tb/lockmem_port_test.sv
module lockmem_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, tgt = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] rdata_a, rdata_b, rdata;
    logic       hold_a, hold_b;
    int         checks = 0, fails = 0, cycles = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    lockmem_port uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr && !tgt), .bus_rd(bus_rd && !tgt), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_a), .core_hold(hold_a));
    lockmem_port uut_b (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr && tgt), .bus_rd(bus_rd && tgt), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_b), .core_hold(hold_b));
    assign rdata = tgt ? rdata_b : rdata_a;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; v = rdata;
    endtask

    task automatic set_addr(logic [15:0] a);
        wr(3'd2, a[15:8]); wr(3'd3, a[7:0]);
    endtask

    task automatic enter();
        wr(3'd0, 8'h04); wr(3'd1, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 core_hold", {7'b0, hold_a}, 8'h00);
        rd(3'd0, v); check("R1 core ctl", v, 8'h00);
        rd(3'd2, v); check("R1 addr hi", v, 8'h00);
        rd(3'd3, v); check("R1 addr lo", v, 8'h00);
        rd(3'd5, v); check("R1 status", v, 8'h00);
    endtask

    task automatic t_core();
        logic [7:0] v;
        wr(3'd0, 8'h04); check("R2 hold after 0x04", {7'b0, hold_a}, 8'h01);
        wr(3'd0, 8'h00); check("R2 unarmed 0x00 keeps hold", {7'b0, hold_a}, 8'h01);
        wr(3'd0, 8'h02); check("R2 hold after 0x02", {7'b0, hold_a}, 8'h01);
        wr(3'd0, 8'h00); check("R2 release", {7'b0, hold_a}, 8'h00);
        rd(3'd0, v); check("R2 readback", v, 8'h00);
    endtask

    task automatic t_gate();
        logic [7:0] v;
        set_addr(16'h0010);
        rd(3'd4, v); check("R3 closed read zero", v, 8'h00);
        rd(3'd5, v); check("R3 closed error", v, 8'h01);
        enter(); wr(3'd1, 8'h40);
        set_addr(16'h0010);
        wr(3'd4, 8'h00);
        rd(3'd3, v); check("R3 addr unchanged", v, 8'h10);
        rd(3'd5, v); check("R3 error set", v, 8'h01);
        wr(3'd1, 8'h00); set_addr(16'h0010);
        rd(3'd5, v); check("R9 error cleared", v, 8'h00);
        rd(3'd4, v); check("R3 memory untouched", v, 8'hFF);
    endtask

    task automatic t_stream();
        logic [7:0] v;
        set_addr(16'h0020);
        wr(3'd4, 8'hA5); wr(3'd4, 8'h3C);
        rd(3'd3, v); check("R5 addr after writes", v, 8'h22);
        set_addr(16'h0020);
        rd(3'd4, v); check("R4 read 0x20", v, 8'hA5);
        rd(3'd4, v); check("R4 read 0x21", v, 8'h3C);
        rd(3'd3, v); check("R4 addr after reads", v, 8'h22);
        check("R11 data held", rdata, 8'h22);
        set_addr(16'h0020); wr(3'd4, 8'hF0);
        set_addr(16'h0020);
        rd(3'd4, v); check("R5 AND program", v, 8'hA0);
        rd(3'd5, v); check("R8 no error", v, 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        set_addr(16'hFFFF);
        rd(3'd4, v); check("R4 fold to security byte", v, 8'hFF);
        rd(3'd2, v); check("R4 wrap hi", v, 8'h00);
        rd(3'd3, v); check("R4 wrap lo", v, 8'h00);
    endtask

    task automatic t_wlock();
        logic [7:0] v;
        set_addr(16'h00FF); wr(3'd4, 8'h7F);
        rd(3'd5, v); check("R8 write lock status", v, 8'h04);
        set_addr(16'h0020); wr(3'd4, 8'h00);
        rd(3'd5, v); check("R6 blocked write error", v, 8'h05);
        rd(3'd3, v); check("R6 addr still steps", v, 8'h21);
        set_addr(16'h0020);
        rd(3'd4, v); check("R6 memory unchanged", v, 8'hA0);
        set_addr(16'h00FF); wr(3'd4, 8'hFF);
        set_addr(16'h00FF); wr(3'd4, 8'h00);
        set_addr(16'h00FF);
        rd(3'd4, v); check("R10 security byte kept", v, 8'h7F);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(3'd5, v); check("R10 lock survives reset", v, 8'h04);
    endtask

    task automatic t_rlock();
        logic [7:0] v;
        tgt = 1'b1;
        enter();
        set_addr(16'h0030); wr(3'd4, 8'h96);
        set_addr(16'h00FF); wr(3'd4, 8'hF7);
        rd(3'd5, v); check("R8 read lock status", v, 8'h02);
        set_addr(16'h0030);
        rd(3'd4, v); check("R7 blocked read zero", v, 8'h00);
        rd(3'd5, v); check("R7 blocked read error", v, 8'h03);
        rd(3'd3, v); check("R7 addr still steps", v, 8'h31);
        set_addr(16'h0031); wr(3'd4, 8'h00);
        rd(3'd5, v); check("R7 writes still allowed", v, 8'h02);
        rd(3'd3, v); check("R5 addr after write", v, 8'h32);
        tgt = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_core();
        t_gate();
        enter();
        t_stream();
        t_wrap();
        t_wlock();
        t_rlock();
        finish_run();
    end
endmodule